// File: doc/BRIEF.md
# Programmable Down-Counting Timer Channel

This block is one timer channel driven through a small word-indexed register port. It keeps a stored reload value and a down-counter. The counter steps on a prescaled version of an input tick, with division by 1, 16 or 256. It can run free, repeat periodically or fire once, and its width is either 16 or 32 bits. When the count passes from one to zero, a raw interrupt flag is latched. An enable bit gates that flag onto the interrupt line.

Software can change the reload value in two ways. One register replaces the reload value and restarts the count from it at once. A second register changes only the stored value, which the counter then picks up at its next natural reload. Reads are combinational from the addressed register. Writes take effect on the rising clock edge. Reset is synchronous and active high.

Top module: `dctr_channel`

## Requirements
- R1: After reset the control register reads 0x20 (interrupt enable only), and the counter, the reload value, the raw flag and `irq_o` are all zero.
- R2: Register word indices are 0 load, 1 current count, 2 control, 3 interrupt clear, 4 raw status (bit 0), 5 masked status (bit 0), 6 deferred load. A write to index 1 is ignored. Reads of any other index return zero, and writes to them change nothing.
- R3: Control bit positions are: bit 0 one-shot, bit 1 32-bit width, bits 3:2 prescale select, bit 5 interrupt enable, bit 6 periodic, bit 7 run. Bit 4 and bits 31:8 read as zero.
- R4: While run is set, the count drops by one on each prescaled tick. While run is clear, the count holds.
- R5: Prescale select 01 divides the tick by 16, 10 divides it by 256, and 00 or 11 passes every tick. Any control write restarts the divider.
- R6: A step from 1 to 0 sets the raw flag. In periodic mode (bit 6 set, bit 0 clear), the next step from 0 loads the stored reload value.
- R7: In free-running mode (bits 0 and 6 clear), a step from 0 loads 0xFFFF in 16-bit mode or 0xFFFFFFFF in 32-bit mode.
- R8: In one-shot mode the counter stays at 0 after expiring and never sets the raw flag again.
- R9: A write to index 0 stores the value and loads the counter with the mode's limit in that same cycle: the maximum count in free-running mode, otherwise the masked reload value. A write to index 0 or index 2 suppresses that cycle's counter step.
- R10: A write to index 6 stores the reload value without touching the count. Indices 0 and 6 both read back the stored value.
- R11: `irq_o` is high exactly when the raw flag and interrupt enable are both set. Index 5 reads 0 while interrupt enable is clear.
- R12: A write of any value to index 3 clears the raw flag. If an expiry happens in the same cycle, the flag stays set.
- R13: A control write that changes the one-shot, periodic or width bit loads the counter with the limit for the new settings, whatever the run bit is.
- R14: In 16-bit mode the count never exceeds 0xFFFF, and loads use only the low 16 bits of the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count tick before prescaling |
| bus_wr_i | input | 1 | Write strobe for the addressed register |
| bus_addr_i | input | ADDR_W | Register word index |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the addressed register |
| irq_o | output | 1 | Masked interrupt |

## Verification
Two events can land in the same clock edge: an interrupt-clear write and a counter expiry. The reference model shows the bench the cycle in which the count sits at 1. The bench issues the clear together with a tick in exactly that cycle, and the raw status must then read 1. A second collision pairs a tick with a load write, and the count must show the written value with no decrement. The deferred-load write is also paired with a tick, and that step must still happen.

// File: rtl/dctr_pkg.sv
package dctr_pkg;

    localparam int BIT_SINGLE   = 0;
    localparam int BIT_WIDE     = 1;
    localparam int BIT_PSC_LO   = 2;
    localparam int BIT_IRQEN    = 5;
    localparam int BIT_PERIODIC = 6;
    localparam int BIT_RUN      = 7;

    localparam int IDX_LOAD   = 0;
    localparam int IDX_VALUE  = 1;
    localparam int IDX_CTRL   = 2;
    localparam int IDX_ICLR   = 3;
    localparam int IDX_RAW    = 4;
    localparam int IDX_MASKED = 5;
    localparam int IDX_BGLOAD = 6;

    typedef enum logic [1:0] {
        PSC_DIV1   = 2'b00,
        PSC_DIV16  = 2'b01,
        PSC_DIV256 = 2'b10,
        PSC_ALT1   = 2'b11
    } psc_e;

    typedef struct packed {
        logic single;
        logic periodic;
        logic wide;
    } shape_t;

    typedef struct packed {
        logic   run;
        logic   irq_en;
        psc_e   psc;
        shape_t shape;
    } ctrl_t;

    localparam ctrl_t CTRL_AT_RESET = '{
        run: 1'b0, irq_en: 1'b1, psc: PSC_DIV1,
        shape: '{single: 1'b0, periodic: 1'b0, wide: 1'b0}
    };

    function automatic ctrl_t ctrl_from_byte(input logic [7:0] b);
        ctrl_t c;
        c.run            = b[BIT_RUN];
        c.irq_en         = b[BIT_IRQEN];
        c.psc            = psc_e'(b[BIT_PSC_LO +: 2]);
        c.shape.single   = b[BIT_SINGLE];
        c.shape.periodic = b[BIT_PERIODIC];
        c.shape.wide     = b[BIT_WIDE];
        return c;
    endfunction

    function automatic logic [7:0] ctrl_to_byte(input ctrl_t c);
        logic [7:0] b;
        b                    = '0;
        b[BIT_RUN]           = c.run;
        b[BIT_IRQEN]         = c.irq_en;
        b[BIT_PSC_LO +: 2]   = c.psc;
        b[BIT_SINGLE]        = c.shape.single;
        b[BIT_PERIODIC]      = c.shape.periodic;
        b[BIT_WIDE]          = c.shape.wide;
        return b;
    endfunction

    function automatic logic is_free(input shape_t s);
        return !s.single && !s.periodic;
    endfunction

endpackage

// File: rtl/dctr_prescale.sv
module dctr_prescale
    import dctr_pkg::*;
#(
    parameter int DIV_A_LOG = 4,
    parameter int DIV_B_LOG = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic restart_i,
    input  logic tick_i,
    input  psc_e psc_i,
    output logic pulse_o
);

    localparam logic [DIV_B_LOG-1:0] TERM_A = DIV_B_LOG'((1 << DIV_A_LOG) - 1);
    localparam logic [DIV_B_LOG-1:0] TERM_B = '1;

    logic [DIV_B_LOG-1:0] div_q;
    logic [DIV_B_LOG-1:0] term;
    logic                 at_term;

    always_comb begin
        case (psc_i)
            PSC_DIV16:  term = TERM_A;
            PSC_DIV256: term = TERM_B;
            default:    term = '0;
        endcase
    end

    assign at_term = (div_q == term);
    assign pulse_o = run_i && tick_i && !restart_i && at_term;

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            div_q <= '0;
        end else if (run_i && tick_i) begin
            div_q <= at_term ? '0 : div_q + 1'b1;
        end
    end

    AST_DIV_BOUND: assert property (@(posedge clk) disable iff (rst)
        (psc_i == PSC_DIV16) |-> (div_q <= TERM_A)); // R5

    AST_DIV_STILL: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !restart_i) |=> $stable(div_q)); // R4

endmodule

// File: rtl/dctr_counter.sv
module dctr_counter
    import dctr_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NARROW_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  shape_t           shape_i,
    input  shape_t           shape_nx_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [CNT_W-1:0] reload_nx_i,
    input  logic             step_i,
    input  logic             hold_i,
    input  logic             load_req_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);

    localparam logic [CNT_W-1:0] NARROW_MASK =
        {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    localparam logic [CNT_W-1:0] WIDE_MASK = '1;

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;

    function automatic logic [CNT_W-1:0] limit_for(input shape_t s,
                                                   input logic [CNT_W-1:0] r);
        logic [CNT_W-1:0] m;
        m = s.wide ? WIDE_MASK : NARROW_MASK;
        return is_free(s) ? m : (r & m);
    endfunction

    always_comb begin
        count_d  = count_q;
        expire_o = 1'b0;
        if (load_req_i) begin
            count_d = limit_for(shape_nx_i, reload_nx_i);
        end else if (step_i && !hold_i) begin
            if (count_q == '0) begin
                if (!shape_i.single) begin
                    count_d = limit_for(shape_i, reload_i);
                end
            end else begin
                count_d  = count_q - 1'b1;
                expire_o = (count_q == CNT_W'(1));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count_o = count_q;

    AST_NARROW_FIT: assert property (@(posedge clk) disable iff (rst)
        !shape_i.wide |-> ((count_q & ~NARROW_MASK) == '0)); // R14

    AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (rst)
        (shape_i.single && count_q == '0 && !load_req_i) |=> (count_q == '0)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !load_req_i) |=> $stable(count_q)); // R4

endmodule

// File: rtl/dctr_regs.sv
module dctr_regs
    import dctr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              expire_i,
    output ctrl_t             ctrl_o,
    output shape_t            shape_nx_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic [CNT_W-1:0]  reload_nx_o,
    output logic              ctrl_wr_o,
    output logic              hold_o,
    output logic              load_req_o,
    output logic              raw_o,
    output logic [DATA_W-1:0] bus_rdata_o
);

    localparam logic [ADDR_W-1:0] A_LOAD   = ADDR_W'(IDX_LOAD);
    localparam logic [ADDR_W-1:0] A_VALUE  = ADDR_W'(IDX_VALUE);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(IDX_CTRL);
    localparam logic [ADDR_W-1:0] A_ICLR   = ADDR_W'(IDX_ICLR);
    localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(IDX_RAW);
    localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(IDX_MASKED);
    localparam logic [ADDR_W-1:0] A_BGLOAD = ADDR_W'(IDX_BGLOAD);

    ctrl_t            ctrl_q;
    ctrl_t            ctrl_nx;
    logic [CNT_W-1:0] reload_q;
    logic             raw_q;
    logic             wr_load, wr_ctrl, wr_iclr, wr_bg;

    assign wr_load = bus_wr_i && (bus_addr_i == A_LOAD);
    assign wr_ctrl = bus_wr_i && (bus_addr_i == A_CTRL);
    assign wr_iclr = bus_wr_i && (bus_addr_i == A_ICLR);
    assign wr_bg   = bus_wr_i && (bus_addr_i == A_BGLOAD);

    assign ctrl_nx     = wr_ctrl ? ctrl_from_byte(bus_wdata_i[7:0]) : ctrl_q;
    assign reload_nx_o = (wr_load || wr_bg) ? bus_wdata_i[CNT_W-1:0] : reload_q;
    assign shape_nx_o  = ctrl_nx.shape;

    assign ctrl_wr_o  = wr_ctrl;
    assign hold_o     = wr_load || wr_ctrl;
    assign load_req_o = wr_load || (wr_ctrl && (ctrl_nx.shape != ctrl_q.shape));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= CTRL_AT_RESET;
            reload_q <= '0;
            raw_q    <= 1'b0;
        end else begin
            ctrl_q   <= ctrl_nx;
            reload_q <= reload_nx_o;
            if (expire_i) begin
                raw_q <= 1'b1;
            end else if (wr_iclr) begin
                raw_q <= 1'b0;
            end
        end
    end

    always_comb begin
        case (bus_addr_i)
            A_LOAD, A_BGLOAD: bus_rdata_o = DATA_W'(reload_q);
            A_VALUE:          bus_rdata_o = DATA_W'(count_i);
            A_CTRL:           bus_rdata_o = DATA_W'(ctrl_to_byte(ctrl_q));
            A_RAW:            bus_rdata_o = DATA_W'(raw_q);
            A_MASKED:         bus_rdata_o = DATA_W'(raw_q && ctrl_q.irq_en);
            default:          bus_rdata_o = '0;
        endcase
    end

    assign ctrl_o   = ctrl_q;
    assign reload_o = reload_q;
    assign raw_o    = raw_q;

    AST_EXPIRE_SETS_RAW: assert property (@(posedge clk) disable iff (rst)
        expire_i |=> raw_q); // R12

    AST_RAW_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(raw_q) |-> $past(expire_i)); // R6

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (wr_iclr && !expire_i) |=> !raw_q); // R12

endmodule

// File: rtl/dctr_channel.sv
module dctr_channel
    import dctr_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 32,
    parameter int NARROW_W  = 16,
    parameter int DIV_A_LOG = 4,
    parameter int DIV_B_LOG = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);

    ctrl_t            ctrl;
    shape_t           shape_nx;
    logic [CNT_W-1:0] reload, reload_nx, count;
    logic             ctrl_wr, hold, load_req, raw, expire, pulse;

    dctr_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .count_i     (count),
        .expire_i    (expire),
        .ctrl_o      (ctrl),
        .shape_nx_o  (shape_nx),
        .reload_o    (reload),
        .reload_nx_o (reload_nx),
        .ctrl_wr_o   (ctrl_wr),
        .hold_o      (hold),
        .load_req_o  (load_req),
        .raw_o       (raw),
        .bus_rdata_o (bus_rdata_o)
    );

    dctr_prescale #(
        .DIV_A_LOG (DIV_A_LOG),
        .DIV_B_LOG (DIV_B_LOG)
    ) u_presc (
        .clk       (clk),
        .rst       (rst),
        .run_i     (ctrl.run),
        .restart_i (ctrl_wr),
        .tick_i    (tick_i),
        .psc_i     (ctrl.psc),
        .pulse_o   (pulse)
    );

    dctr_counter #(
        .CNT_W    (CNT_W),
        .NARROW_W (NARROW_W)
    ) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .run_i       (ctrl.run),
        .shape_i     (ctrl.shape),
        .shape_nx_i  (shape_nx),
        .reload_i    (reload),
        .reload_nx_i (reload_nx),
        .step_i      (pulse),
        .hold_i      (hold),
        .load_req_i  (load_req),
        .count_o     (count),
        .expire_o    (expire)
    );

    assign irq_o = raw && ctrl.irq_en;

    AST_NO_STEP_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_i && bus_addr_i == ADDR_W'(IDX_LOAD)) |-> !expire); // R9

endmodule

// File: tb/dctr_channel_bench.sv
module dctr_channel_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tk  = 1'b0;
    logic        wr  = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wd  = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    bit        m_one, m_big, m_per, m_en, m_ie, m_raw;
    int        m_pre, m_div;
    bit [31:0] m_rel, m_cnt;

    always #2 clk = ~clk;

    dctr_channel u_dctr_channel (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tk),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wd),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    function automatic bit [31:0] m_lim();
        bit [31:0] m = m_big ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        if (!m_one && !m_per) return m;
        return m_rel & m;
    endfunction

    function automatic bit [31:0] m_read(input int a);
        case (a)
            0, 6: return m_rel;
            1:    return m_cnt;
            2:    return {24'd0, m_en, m_per, m_ie, 1'b0, 2'(m_pre), m_big, m_one};
            4:    return {31'd0, m_raw};
            5:    return {31'd0, m_raw && m_ie};
            default: return 32'd0;
        endcase
    endfunction

    task automatic m_reset();
        m_one = 0; m_big = 0; m_per = 0; m_en = 0; m_ie = 1; m_raw = 0;
        m_pre = 0; m_div = 0; m_rel = 0; m_cnt = 0;
    endtask

    task automatic m_update(input bit w, input int a, input bit [31:0] d, input bit t);
        bit hold  = w && (a == 0 || a == 2);
        bit pulse = 0;
        bit fire  = 0;
        int term;
        if (w && a == 2) begin
            m_div = 0;
        end else if (m_en && t) begin
            term = (m_pre == 1) ? 15 : (m_pre == 2) ? 255 : 0;
            if (m_div == term) begin m_div = 0; pulse = 1; end
            else m_div++;
        end
        if (pulse && !hold) begin
            if (m_cnt == 0) begin
                if (!m_one) m_cnt = m_lim();
            end else begin
                if (m_cnt == 1) fire = 1;
                m_cnt--;
            end
        end
        if (w) begin
            case (a)
                0: begin m_rel = d; m_cnt = m_lim(); end
                2: begin
                    bit changed = (m_one != d[0]) || (m_big != d[1]) || (m_per != d[6]);
                    m_one = d[0]; m_big = d[1]; m_pre = int'(d[3:2]);
                    m_ie = d[5]; m_per = d[6]; m_en = d[7];
                    if (changed) m_cnt = m_lim();
                end
                3: m_raw = 0;
                6: m_rel = d;
                default: ;
            endcase
        end
        if (fire) m_raw = 1;
    endtask

    task automatic chk(input string req, input string what, input bit [31:0] act, input bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input bit w, input int a, input bit [31:0] d, input bit t);
        wr = w; addr = 4'(a); wd = d; tk = t;
        @(posedge clk);
        m_update(w, a, d, t);
        @(negedge clk);
        chk(cur_req, $sformatf("model compare rdata idx %0d", a), rdata, m_read(a));
        chk(cur_req, "model compare irq", 32'(irq), 32'(m_raw && m_ie));
    endtask

    task automatic wreg(input int a, input bit [31:0] d);
        step(1, a, d, 0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(0, 1, 0, 1);
    endtask

    task automatic rd(input int a, input string req, input bit [31:0] exp);
        step(0, a, 0, 0);
        chk(req, $sformatf("read idx %0d", a), rdata, exp);
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog expired, run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        cur_req = "R1";
        rd(2, "R1", 32'h20);
        rd(1, "R1", 0);
        rd(4, "R1", 0);
        rd(0, "R1", 0);
        chk("R1", "irq after reset", 32'(irq), 0);

        // R3 / R9: periodic 16-bit, divide by 1
        cur_req = "R9";
        wreg(0, 5);
        wreg(2, 32'hE0);
        rd(2, "R3", 32'hE0);
        rd(1, "R9", 5);
        cur_req = "R4";
        ticks(4);
        rd(1, "R4", 1);
        cur_req = "R6";
        ticks(1);
        rd(1, "R6", 0);
        chk("R11", "irq on expiry", 32'(irq), 1);
        ticks(1);
        rd(1, "R6", 5);
        rd(4, "R6", 1);
        rd(5, "R11", 1);

        // R11: mask off
        cur_req = "R11";
        wreg(2, 32'hC0);
        chk("R11", "irq masked", 32'(irq), 0);
        rd(5, "R11", 0);
        rd(4, "R11", 1);
        cur_req = "R12";
        wreg(3, 32'hDEAD);
        rd(4, "R12", 0);
        wreg(2, 32'hE0);

        // R12: clear in same cycle as expiry
        while (m_cnt != 1) step(0, 1, 0, 1);
        step(1, 3, 32'h1, 1);
        rd(4, "R12", 1);
        rd(1, "R12", 0);

        // R10: deferred load
        cur_req = "R10";
        ticks(1);
        rd(1, "R10", 5);
        step(1, 6, 9, 1);
        rd(1, "R10", 4);
        rd(0, "R10", 9);
        rd(6, "R10", 9);
        while (m_cnt != 0) step(0, 1, 0, 1);
        ticks(1);
        rd(1, "R10", 9);

        // R2: ignored and unmapped accesses
        cur_req = "R2";
        wreg(1, 32'h1234);
        rd(1, "R2", 9);
        rd(7, "R2", 0);
        rd(15, "R2", 0);
        wreg(7, 32'hFFFF);
        wreg(13, 32'h0);
        rd(0, "R2", 9);
        rd(2, "R2", 32'hE0);

        // R5: prescaler
        cur_req = "R5";
        wreg(2, 32'hE4);
        ticks(15);
        rd(1, "R5", 9);
        ticks(1);
        rd(1, "R5", 8);
        wreg(2, 32'hE8);
        ticks(255);
        rd(1, "R5", 8);
        ticks(1);
        rd(1, "R5", 7);
        wreg(2, 32'hEC);
        ticks(1);
        rd(1, "R5", 6);

        // R7 / R13: free-running wrap
        cur_req = "R7";
        wreg(3, 0);
        wreg(2, 32'hA0);
        rd(1, "R13", 32'hFFFF);
        ticks(65534);
        rd(1, "R7", 1);
        ticks(1);
        rd(4, "R7", 1);
        ticks(1);
        rd(1, "R7", 32'hFFFF);
        wreg(2, 32'hA2);
        rd(1, "R13", 32'hFFFF_FFFF);
        ticks(1);
        rd(1, "R4", 32'hFFFF_FFFE);

        // R8: one-shot
        cur_req = "R8";
        wreg(3, 0);
        wreg(0, 3);
        rd(1, "R9", 32'hFFFF_FFFF);
        wreg(2, 32'hA1);
        rd(1, "R13", 3);
        ticks(3);
        rd(4, "R8", 1);
        wreg(3, 0);
        ticks(5);
        rd(1, "R8", 0);
        rd(4, "R8", 0);

        // R14: narrow masking
        cur_req = "R14";
        wreg(0, 32'h12345);
        rd(1, "R14", 32'h2345);
        rd(0, "R14", 32'h12345);

        // R4: disabled holds
        cur_req = "R4";
        wreg(2, 32'h21);
        ticks(3);
        rd(1, "R4", 32'h2345);

        // R9: load write beats tick
        cur_req = "R9";
        wreg(2, 32'hA1);
        ticks(1);
        rd(1, "R9", 32'h2344);
        step(1, 0, 7, 1);
        rd(1, "R9", 7);

        // R3: reserved bits
        cur_req = "R3";
        wreg(2, 32'hFFFF_FF3F);
        rd(2, "R3", 32'h2F);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule